// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit physical address. It holds four 16-bit segment registers: extra, code, stack and data. For each request it picks one of them and adds the offset to the segment value shifted left by four bit positions.

The segment is normally chosen from two inputs: the kind of access and the base register that produced the offset. An override input can name a different segment for any access except a string destination. The segment registers are loaded through a simple write port. The address appears one cycle after the request, registered, together with a valid strobe.

Top module: `seg_addr_gen`

## Requirements
- R1: When `addrValid` is high, `physAddr` equals (segment value × 16) + offset for the request made one cycle earlier. For example, a code segment of 34BAh and an offset of 8AB4h give 3D654h.
- R2: The sum wraps modulo 2^20. Any carry out of bit 19 is discarded.
- R3: A code fetch (`accType`=0) with no override uses the code segment (index 1).
- R4: With no override, a stack access (`accType`=1) uses the stack segment (index 2), whatever the base register. A data access (`accType`=2) with base SP (`baseSel`=3) or BP (`baseSel`=4) also uses the stack segment.
- R5: A data access with no override and base BX (0), SI (1) or DI (2) uses the data segment (index 3). Base codes 5 to 7 also select the data segment.
- R6: A string-destination access (`accType`=3) always uses the extra segment (index 0). This holds even when `ovrEn` is high.
- R7: For access types 0, 1 and 2, an asserted `ovrEn` replaces the default segment with the one named by `ovrSeg`.
- R8: A segment register written in a given cycle (`segWrEn`, index `segWrSel`) is used only by requests from the next cycle onward. A request in the same cycle as the write sees the old value.
- R9: `addrValid` is high in exactly the cycle after each request cycle. `physAddr` holds its value through cycles with no request.
- R10: Reset clears all four segment registers, `physAddr` and `addrValid` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Address request this cycle |
| accType | input | 2 | 0 code fetch, 1 stack, 2 data, 3 string destination |
| baseSel | input | 3 | 0 BX, 1 SI, 2 DI, 3 SP, 4 BP |
| offset | input | 16 | Offset within the segment |
| ovrEn | input | 1 | Segment override enable |
| ovrSeg | input | 2 | Override segment index (0 extra, 1 code, 2 stack, 3 data) |
| segWrEn | input | 1 | Segment register write strobe |
| segWrSel | input | 2 | Segment register index to write |
| segWrData | input | 16 | Value to write |
| physAddr | output | 20 | Registered physical address |
| addrValid | output | 1 | High for one cycle per request |

## Verification
The checker assumes that the segment registers change only through the write port and through reset. It keeps its own shadow copy of the registers, updated from that port, and compares every valid address against it. It also assumes that inputs settle well before the clock edge. The bench therefore drives all inputs on the falling edge and issues at most one request per cycle. It puts a write and a request in the same cycle only where the old-value rule of R8 is the point of the test.

// File: rtl/seg_addr_pkg.sv
package seg_addr_pkg;
  localparam int SEG_IDX_W = 2;
  localparam int NUM_SEG   = 1 << SEG_IDX_W;

  localparam logic [1:0] ACC_CODE   = 2'd0;
  localparam logic [1:0] ACC_STACK  = 2'd1;
  localparam logic [1:0] ACC_DATA   = 2'd2;
  localparam logic [1:0] ACC_STRDST = 2'd3;

  localparam logic [2:0] BASE_BX = 3'd0;
  localparam logic [2:0] BASE_SI = 3'd1;
  localparam logic [2:0] BASE_DI = 3'd2;
  localparam logic [2:0] BASE_SP = 3'd3;
  localparam logic [2:0] BASE_BP = 3'd4;

  localparam logic [SEG_IDX_W-1:0] SEG_EXTRA = 2'd0;
  localparam logic [SEG_IDX_W-1:0] SEG_CODE  = 2'd1;
  localparam logic [SEG_IDX_W-1:0] SEG_STACK = 2'd2;
  localparam logic [SEG_IDX_W-1:0] SEG_DATA  = 2'd3;

  // strobes from control to datapath
  typedef struct packed {
    logic                 load;
    logic [SEG_IDX_W-1:0] seg;
  } ctrlBus_t;
endpackage

// File: rtl/seg_addr_ctrl.sv
module seg_addr_ctrl
  import seg_addr_pkg::*;
(
  input  logic                 reqValid,
  input  logic [1:0]           accType,
  input  logic [2:0]           baseSel,
  input  logic                 ovrEn,
  input  logic [SEG_IDX_W-1:0] ovrSeg,
  output ctrlBus_t             ctrl
);
  logic [SEG_IDX_W-1:0] defSeg;
  logic                 ovrAllowed;

  // default segment from access kind and base register (R3, R4, R5, R6)
  always_comb begin
    unique case (accType)
      ACC_CODE:   defSeg = SEG_CODE;
      ACC_STACK:  defSeg = SEG_STACK;
      ACC_STRDST: defSeg = SEG_EXTRA;
      default:    defSeg = (baseSel == BASE_SP || baseSel == BASE_BP) ? SEG_STACK : SEG_DATA;
    endcase
  end

  // override never touches string destinations (R6, R7)
  assign ovrAllowed = ovrEn && (accType != ACC_STRDST);

  always_comb begin
    ctrl.load = reqValid;
    ctrl.seg  = ovrAllowed ? ovrSeg : defSeg;
  end
endmodule

// File: rtl/seg_addr_dp.sv
module seg_addr_dp
  import seg_addr_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = SEG_W + SEG_SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  ctrlBus_t             ctrl,
  input  logic [OFF_W-1:0]     offset,
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrSel,
  input  logic [SEG_W-1:0]     segWrData,
  output logic [PA_W-1:0]      physAddr,
  output logic                 addrValid
);
  logic [SEG_W-1:0] segFile [NUM_SEG];
  logic [PA_W-1:0]  segBase;
  logic [PA_W-1:0]  sumAddr;

  // one register per segment; a write shows up at the next edge (R8, R10)
  for (genvar i = 0; i < NUM_SEG; i++) begin : g_seg
    always_ff @(posedge clk) begin
      if (!rstN)
        segFile[i] <= '0;
      else if (segWrEn && segWrSel == SEG_IDX_W'(i))
        segFile[i] <= segWrData;
    end
  end

  // shifted base plus zero-extended offset, truncated to PA_W bits (R1, R2)
  assign segBase = {segFile[ctrl.seg], {SEG_SHIFT{1'b0}}};
  assign sumAddr = segBase + PA_W'(offset);

  // registered result (R9, R10)
  always_ff @(posedge clk) begin
    if (!rstN) begin
      physAddr  <= '0;
      addrValid <= 1'b0;
    end else begin
      addrValid <= ctrl.load;
      if (ctrl.load)
        physAddr <= sumAddr;
    end
  end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
  import seg_addr_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = SEG_W + SEG_SHIFT
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic [1:0]           accType,
  input  logic [2:0]           baseSel,
  input  logic [OFF_W-1:0]     offset,
  input  logic                 ovrEn,
  input  logic [SEG_IDX_W-1:0] ovrSeg,
  input  logic                 segWrEn,
  input  logic [SEG_IDX_W-1:0] segWrSel,
  input  logic [SEG_W-1:0]     segWrData,
  output logic [PA_W-1:0]      physAddr,
  output logic                 addrValid
);
  ctrlBus_t ctrlBus;

  seg_addr_ctrl u_ctrl (
    .reqValid (reqValid),
    .accType  (accType),
    .baseSel  (baseSel),
    .ovrEn    (ovrEn),
    .ovrSeg   (ovrSeg),
    .ctrl     (ctrlBus)
  );

  seg_addr_dp #(
    .SEG_W     (SEG_W),
    .OFF_W     (OFF_W),
    .SEG_SHIFT (SEG_SHIFT)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .ctrl      (ctrlBus),
    .offset    (offset),
    .segWrEn   (segWrEn),
    .segWrSel  (segWrSel),
    .segWrData (segWrData),
    .physAddr  (physAddr),
    .addrValid (addrValid)
  );
endmodule

// File: rtl/seg_addr_chk.sv
module seg_addr_chk
  import seg_addr_pkg::*;
#(
  parameter int SEG_W     = 16,
  parameter int OFF_W     = 16,
  parameter int SEG_SHIFT = 4,
  localparam int PA_W     = SEG_W + SEG_SHIFT
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic [1:0]           accType,
  input logic [OFF_W-1:0]     offset,
  input logic                 ovrEn,
  input logic [SEG_IDX_W-1:0] ovrSeg,
  input logic                 segWrEn,
  input logic [SEG_IDX_W-1:0] segWrSel,
  input logic [SEG_W-1:0]     segWrData,
  input ctrlBus_t             ctrlBus,
  input logic [PA_W-1:0]      physAddr,
  input logic                 addrValid
);
  logic [SEG_W-1:0] shadow [NUM_SEG];
  logic [PA_W-1:0]  expAddr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SEG; i++) shadow[i] <= '0;
      expAddr <= '0;
    end else begin
      if (segWrEn) shadow[segWrSel] <= segWrData;
      if (reqValid) expAddr <= {shadow[ctrlBus.seg], {SEG_SHIFT{1'b0}}} + PA_W'(offset);
    end
  end

  // also covers R2 (wrap) and R8 (old value on same-cycle write)
  assert_addr_match_R1: assert property (@(posedge clk) disable iff (!rstN)
    addrValid |-> physAddr == expAddr);

  assert_valid_latency_R9: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> addrValid);

  assert_no_spurious_valid_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !addrValid);

  assert_hold_addr_R9: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> $stable(physAddr));

  assert_code_seg_R3: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !ovrEn && accType == ACC_CODE) |-> ctrlBus.seg == SEG_CODE);

  assert_strdst_extra_R6: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && accType == ACC_STRDST) |-> ctrlBus.seg == SEG_EXTRA);

  assert_override_R7: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && ovrEn && accType != ACC_STRDST) |-> ctrlBus.seg == ovrSeg);
endmodule

bind seg_addr_gen seg_addr_chk #(
  .SEG_W     (SEG_W),
  .OFF_W     (OFF_W),
  .SEG_SHIFT (SEG_SHIFT)
) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .accType   (accType),
  .offset    (offset),
  .ovrEn     (ovrEn),
  .ovrSeg    (ovrSeg),
  .segWrEn   (segWrEn),
  .segWrSel  (segWrSel),
  .segWrData (segWrData),
  .ctrlBus   (ctrlBus),
  .physAddr  (physAddr),
  .addrValid (addrValid)
);

// File: tb/seg_addr_gen_tb.sv
`timescale 1ns/1ps
module seg_addr_gen_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic [1:0]  accType = '0;
  logic [2:0]  baseSel = '0;
  logic [15:0] offset = '0;
  logic        ovrEn = 1'b0;
  logic [1:0]  ovrSeg = '0;
  logic        segWrEn = 1'b0;
  logic [1:0]  segWrSel = '0;
  logic [15:0] segWrData = '0;
  logic [19:0] physAddr;
  logic        addrValid;

  int nChecks = 0;
  int nFails  = 0;
  logic [15:0] mSeg [4];

  typedef struct {
    logic [19:0] addr;
    string       tag;
  } expItem_t;
  expItem_t scb[$];

  always #2 clk = ~clk;

  seg_addr_gen u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .accType(accType),
    .baseSel(baseSel), .offset(offset), .ovrEn(ovrEn), .ovrSeg(ovrSeg),
    .segWrEn(segWrEn), .segWrSel(segWrSel), .segWrData(segWrData),
    .physAddr(physAddr), .addrValid(addrValid)
  );

  task automatic check(input bit ok, input string tag, input logic [19:0] act, input logic [19:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=%05h expected=%05h", tag, act, exp);
    end
  endtask

  // segment choice from the requirements: 0 extra, 1 code, 2 stack, 3 data
  function automatic logic [1:0] pickSeg(input logic [1:0] a, input logic [2:0] b,
                                         input logic ov, input logic [1:0] os);
    if (a == 2'd3) return 2'd0;
    if (ov) return os;
    if (a == 2'd0) return 2'd1;
    if (a == 2'd1) return 2'd2;
    if (b == 3'd3 || b == 3'd4) return 2'd2;
    return 2'd3;
  endfunction

  task automatic drive(input bit doReq, input logic [1:0] a, input logic [2:0] b,
                       input logic [15:0] off, input logic ov, input logic [1:0] os,
                       input bit doWr, input logic [1:0] ws, input logic [15:0] wd,
                       input string tag);
    logic [19:0] e;
    @(negedge clk);
    reqValid = doReq; accType = a; baseSel = b; offset = off; ovrEn = ov; ovrSeg = os;
    segWrEn = doWr; segWrSel = ws; segWrData = wd;
    if (doReq) begin
      e = {mSeg[pickSeg(a, b, ov, os)], 4'h0} + {4'h0, off};
      scb.push_back('{addr: e, tag: tag});
    end
    if (doWr) mSeg[ws] = wd;
  endtask

  task automatic req(input logic [1:0] a, input logic [2:0] b, input logic [15:0] off,
                     input logic ov, input logic [1:0] os, input string tag);
    drive(1'b1, a, b, off, ov, os, 1'b0, 2'd0, 16'h0, tag);
  endtask

  task automatic wrSeg(input logic [1:0] ws, input logic [15:0] wd);
    drive(1'b0, 2'd0, 3'd0, 16'h0, 1'b0, 2'd0, 1'b1, ws, wd, "");
  endtask

  task automatic idle();
    drive(1'b0, 2'd0, 3'd0, 16'h0, 1'b0, 2'd0, 1'b0, 2'd0, 16'h0, "");
  endtask

  // monitor: pops the scoreboard when a valid address comes out (R9 timing)
  always begin
    @(posedge clk);
    #1;
    if (rstN) begin
      if (scb.size() > 0) begin
        expItem_t it;
        it = scb.pop_front();
        check(addrValid === 1'b1, {it.tag, " valid (R9)"}, {19'h0, addrValid}, 20'h1);
        check(physAddr === it.addr, it.tag, physAddr, it.addr);
      end else if (addrValid !== 1'b0) begin
        check(1'b0, "R9 valid without request", {19'h0, addrValid}, 20'h0);
      end
    end
  end

  initial begin
    repeat (5000) @(posedge clk);
    check(1'b0, "watchdog expired", 20'h0, 20'h0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    logic [19:0] held;
    for (int i = 0; i < 4; i++) mSeg[i] = '0;
    repeat (3) @(negedge clk);
    check(physAddr === 20'h0, "R10 reset address", physAddr, 20'h0);
    check(addrValid === 1'b0, "R10 reset valid", {19'h0, addrValid}, 20'h0);
    rstN = 1'b1;
    // R10: segments cleared by reset, so data access gives the bare offset
    req(2'd2, 3'd0, 16'h1234, 1'b0, 2'd0, "R10 cleared segment");
    wrSeg(2'd1, 16'h34BA);
    req(2'd0, 3'd0, 16'h8AB4, 1'b0, 2'd0, "R1 R3 code fetch 3D654");
    idle();
    check(physAddr === 20'h3D654, "R1 literal example", physAddr, 20'h3D654);
    wrSeg(2'd2, 16'h1000);
    wrSeg(2'd3, 16'h2000);
    wrSeg(2'd0, 16'h3000);
    req(2'd2, 3'd3, 16'h0010, 1'b0, 2'd0, "R4 data via SP");
    req(2'd2, 3'd4, 16'h0ABC, 1'b0, 2'd0, "R4 data via BP");
    req(2'd1, 3'd0, 16'h0022, 1'b0, 2'd0, "R4 stack access base BX");
    req(2'd2, 3'd0, 16'h0101, 1'b0, 2'd0, "R5 data via BX");
    req(2'd2, 3'd1, 16'h0202, 1'b0, 2'd0, "R5 data via SI");
    req(2'd2, 3'd2, 16'h0303, 1'b0, 2'd0, "R5 data via DI");
    req(2'd2, 3'd6, 16'h0404, 1'b0, 2'd0, "R5 unlisted base code");
    req(2'd3, 3'd2, 16'h0050, 1'b0, 2'd0, "R6 string dest");
    req(2'd3, 3'd2, 16'h0060, 1'b1, 2'd3, "R6 override ignored");
    req(2'd2, 3'd4, 16'h0070, 1'b1, 2'd3, "R7 override BP to data");
    req(2'd0, 3'd0, 16'h0080, 1'b1, 2'd0, "R7 override code to extra");
    req(2'd1, 3'd0, 16'h0090, 1'b1, 2'd1, "R7 override stack to code");
    idle();
    wrSeg(2'd3, 16'hFFFF);
    req(2'd2, 3'd0, 16'h0020, 1'b0, 2'd0, "R2 wrap past 20 bits");
    req(2'd2, 3'd0, 16'hFFFF, 1'b0, 2'd0, "R2 wrap max offset");
    // R8: write and request in the same cycle
    drive(1'b1, 2'd2, 3'd1, 16'h0004, 1'b0, 2'd0, 1'b1, 2'd3, 16'h4000, "R8 same-cycle old value");
    req(2'd2, 3'd1, 16'h0004, 1'b0, 2'd0, "R8 next-cycle new value");
    idle();
    held = physAddr;
    idle(); idle(); idle();
    check(physAddr === held, "R9 hold while idle", physAddr, held);
    check(physAddr === 20'h40004, "R8 held new value", physAddr, 20'h40004);
    idle();
    check(scb.size() == 0, "R9 all results delivered", 20'(scb.size()), 20'h0);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule